// File: doc/BRIEF.md
# Vector Condition Field Writer

This block records a 4-bit condition field for every element produced by a vectorised arithmetic operation that has its record flag set. An upstream unit presents one signed element result per cycle, with the element's position in the vector, the vector length, a flag that says whether the operation is integer or floating point, a flag that marks the destination as scalar, and the current sticky overflow bit. The block classifies the result as negative, positive or zero. It writes the resulting field into a 64-entry condition field file.

Vector integer results fill fields upward from field 8, and vector floating-point results fill fields upward from field 32. Both bases are multiples of 8, so each vector starts on a batch boundary. A scalar destination uses the conventional fields instead: field 0 for integer and field 1 for floating point. A read port returns any aligned group of 8 fields as one 32-bit word. A one-cycle done pulse marks the write of the last element of the vector.

Top module: `vcr_writer`

## Requirements
- R1: The condition field written for an element has bit 3 set when the result is negative, bit 2 set when it is greater than zero, and bit 1 set when it is zero. Bit 0 is a copy of `ovf_sticky` for that element.
- R2: For an integer vector element (`is_fp`=0, `dst_scalar`=0) with index i, the field at address 8+i is written.
- R3: For a floating-point vector element (`is_fp`=1, `dst_scalar`=0) with index i, the field at address 32+i is written.
- R4: A field address of 64 or above wraps modulo 64. For example, floating-point index 40 writes field 8.
- R5: When `dst_scalar`=1, integer results write field 0 and floating-point results write field 1, whatever the element index.
- R6: `rd_sel`=k returns fields 8k to 8k+7 on `rd_data`. Field 8k is in bits 31:28, field 8k+1 is in bits 27:24, and so on, so field 8k+7 is in bits 3:0.
- R7: A write happens only on a clock edge where `in_valid` and `in_ready` are both high, and it changes only the one addressed field. Inputs presented while `in_valid` is low have no effect.
- R8: `done` is high for exactly the cycle that follows the acceptance of an element whose index equals `vec_len`-1. It is low in every other cycle.
- R9: Synchronous reset clears every field to 0 and clears `done`. `in_ready` is high whenever reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An element result is present |
| in_ready | output | 1 | The block accepts an element this cycle |
| elem_result | input | DATA_W | Signed element result |
| elem_idx | input | 6 | Element index within the vector |
| vec_len | input | 7 | Vector length, 1 to 64 |
| is_fp | input | 1 | 1 = floating-point operation, 0 = integer |
| dst_scalar | input | 1 | Destination is marked scalar |
| ovf_sticky | input | 1 | Sticky overflow bit to copy into the field |
| rd_sel | input | 3 | Selects an aligned batch of 8 fields |
| rd_data | output | 32 | Batch read data, lowest field in bits 31:28 |
| done | output | 1 | Pulse after the last element is written |

## Verification
The assertions assume that `elem_idx` stays below 64 and that `vec_len` is between 1 and 64 whenever `in_valid` is high. They also assume that the upstream unit presents well-defined values on every input while it asserts `in_valid`. The stimulus draws indices, lengths and results from `$urandom` within these ranges. It mixes zero, small positive, small negative and extreme values, and it sets the overflow bit at random. Directed cases cover indices that wrap past field 63, scalar destinations with non-zero indices, and idle cycles that carry garbage data on the inputs with `in_valid` low.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
    localparam int FIELDS        = 64;
    localparam int FLD_W         = $clog2(FIELDS);
    localparam int COND_W        = 4;
    localparam int BATCH_FIELDS  = 8;
    localparam int BATCH_BITS    = BATCH_FIELDS * COND_W;
    localparam int BATCHES       = FIELDS / BATCH_FIELDS;
    localparam int BATCH_W       = $clog2(BATCHES);
    localparam int SLOT_W        = $clog2(BATCH_FIELDS);
    localparam int INT_VEC_BASE  = 8;
    localparam int FP_VEC_BASE   = 32;
    localparam int INT_SCALAR_FLD = 0;
    localparam int FP_SCALAR_FLD  = 1;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic ovf;
    } cond_t;

    typedef struct packed {
        logic [FLD_W-1:0] addr;
        cond_t            cond;
    } fld_wr_t;

    function automatic cond_t classify(input logic sign_bit, input logic is_zero,
                                       input logic ovf_in);
        cond_t c;
        c.neg  = sign_bit;
        c.zero = is_zero;
        c.pos  = !sign_bit && !is_zero;
        c.ovf  = ovf_in;
        return c;
    endfunction
endpackage

// File: rtl/vcr_cond_gen.sv
module vcr_cond_gen
    import vcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W-1:0] result,
    input  logic                     ovf_in,
    output cond_t                    cond
);
    always_comb begin
        cond = classify(result[DATA_W-1], (result == '0), ovf_in);
    end
endmodule

// File: rtl/vcr_field_map.sv
module vcr_field_map
    import vcr_pkg::*;
(
    input  logic [FLD_W-1:0] idx,
    input  logic             is_fp,
    input  logic             scalar,
    output logic [FLD_W-1:0] addr
);
    logic [FLD_W-1:0] vec_base;

    always_comb begin
        vec_base = is_fp ? FLD_W'(FP_VEC_BASE) : FLD_W'(INT_VEC_BASE);
        if (scalar)
            addr = is_fp ? FLD_W'(FP_SCALAR_FLD) : FLD_W'(INT_SCALAR_FLD);
        else
            addr = vec_base + idx;
    end
endmodule

// File: rtl/vcr_field_file.sv
module vcr_field_file
    import vcr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  fld_wr_t               wr,
    input  logic [BATCH_W-1:0]    rd_sel,
    output logic [BATCH_BITS-1:0] rd_data
);
    logic [COND_W-1:0] fld_q [FIELDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FIELDS; i++) fld_q[i] <= '0;
        end else if (wr_en) begin
            fld_q[wr.addr] <= wr.cond;
        end
    end

    for (genvar s = 0; s < BATCH_FIELDS; s++) begin : g_slot
        logic [FLD_W-1:0] slot_addr;
        assign slot_addr = {rd_sel, SLOT_W'(s)};
        assign rd_data[BATCH_BITS-1-s*COND_W -: COND_W] = fld_q[slot_addr];
    end
endmodule

// File: rtl/vcr_writer.sv
module vcr_writer
    import vcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] elem_result,
    input  logic [5:0]               elem_idx,
    input  logic [6:0]               vec_len,
    input  logic                     is_fp,
    input  logic                     dst_scalar,
    input  logic                     ovf_sticky,
    input  logic [2:0]               rd_sel,
    output logic [31:0]              rd_data,
    output logic                     done
);
    logic    accept;
    logic    last_elem;
    cond_t   wr_cond;
    logic [FLD_W-1:0] wr_addr;
    fld_wr_t wr_pkt;
    logic    done_q;

    assign in_ready  = !rst;
    assign accept    = in_valid && in_ready;
    assign last_elem = ({1'b0, elem_idx} == (vec_len - 7'd1));

    vcr_cond_gen #(.DATA_W(DATA_W)) cond_i (
        .result (elem_result),
        .ovf_in (ovf_sticky),
        .cond   (wr_cond)
    );

    vcr_field_map map_i (
        .idx    (elem_idx),
        .is_fp  (is_fp),
        .scalar (dst_scalar),
        .addr   (wr_addr)
    );

    assign wr_pkt.addr = wr_addr;
    assign wr_pkt.cond = wr_cond;

    vcr_field_file file_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr      (wr_pkt),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= accept && last_elem;
    end

    assign done = done_q;
endmodule

// File: rtl/vcr_writer_chk.sv
module vcr_writer_chk
    import vcr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [5:0]       elem_idx,
    input logic [6:0]       vec_len,
    input logic             is_fp,
    input logic             dst_scalar,
    input logic             ovf_sticky,
    input logic             done,
    input cond_t            wr_cond,
    input logic [FLD_W-1:0] wr_addr
);
    logic acc;
    logic is_last;
    assign acc     = in_valid && in_ready;
    assign is_last = ({1'b0, elem_idx} == (vec_len - 7'd1));

    AST_COND_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        acc |-> $countones({wr_cond.neg, wr_cond.pos, wr_cond.zero}) == 1); // R1
    AST_OVF_COPIED: assert property (@(posedge clk) disable iff (rst)
        acc |-> wr_cond.ovf == ovf_sticky); // R1
    AST_INT_VEC_START: assert property (@(posedge clk) disable iff (rst)
        acc && !dst_scalar && !is_fp && elem_idx == '0 |-> wr_addr == FLD_W'(INT_VEC_BASE)); // R2
    AST_FP_VEC_START: assert property (@(posedge clk) disable iff (rst)
        acc && !dst_scalar && is_fp && elem_idx == '0 |-> wr_addr == FLD_W'(FP_VEC_BASE)); // R3
    AST_SCALAR_FIELD: assert property (@(posedge clk) disable iff (rst)
        acc && dst_scalar |-> wr_addr == (is_fp ? FLD_W'(FP_SCALAR_FLD) : FLD_W'(INT_SCALAR_FLD))); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        acc && is_last |=> done); // R8
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !(acc && is_last) |=> !done); // R8
endmodule

bind vcr_writer vcr_writer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .elem_idx   (elem_idx),
    .vec_len    (vec_len),
    .is_fp      (is_fp),
    .dst_scalar (dst_scalar),
    .ovf_sticky (ovf_sticky),
    .done       (done),
    .wr_cond    (wr_cond),
    .wr_addr    (wr_addr)
);

// File: tb/vcr_writer_tb.sv
`timescale 1ns/1ps
module vcr_writer_tb_top;
    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic signed [31:0] elem_result;
    logic [5:0]         elem_idx;
    logic [6:0]         vec_len;
    logic               is_fp;
    logic               dst_scalar;
    logic               ovf_sticky;
    logic [2:0]         rd_sel;
    logic [31:0]        rd_data;
    logic               done;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [64];

    always #4 clk = ~clk;

    vcr_writer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .elem_result(elem_result), .elem_idx(elem_idx), .vec_len(vec_len),
        .is_fp(is_fp), .dst_scalar(dst_scalar), .ovf_sticky(ovf_sticky),
        .rd_sel(rd_sel), .rd_data(rd_data), .done(done)
    );

    function automatic logic [3:0] exp_cond(input logic signed [31:0] r, input logic so);
        return {r < 0, r > 0, r == 0, so};
    endfunction

    function automatic int exp_addr(input int idx, input logic fp, input logic sc);
        if (sc) return fp ? 1 : 0;
        return ((fp ? 32 : 8) + idx) % 64;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_file(input string req);
        for (int b = 0; b < 8; b++) begin
            logic [31:0] e;
            for (int s = 0; s < 8; s++) e[31-4*s -: 4] = model[b*8+s];
            rd_sel = 3'(b);
            #1;
            check(req, rd_data, e);
        end
    endtask

    task automatic send(input logic signed [31:0] r, input int idx, input int vl,
                        input logic fp, input logic sc, input logic so, input string req);
        @(negedge clk);
        in_valid = 1'b1; elem_result = r; elem_idx = 6'(idx); vec_len = 7'(vl);
        is_fp = fp; dst_scalar = sc; ovf_sticky = so;
        #1;
        check("R9 ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        model[exp_addr(idx, fp, sc)] = exp_cond(r, so);
        check({"R8 done ", req}, {31'd0, done}, {31'd0, idx == vl - 1});
    endtask

    function automatic logic signed [31:0] rand_result();
        case ($urandom % 5)
            0: return 32'sd0;
            1: return 32'(($urandom % 100) + 1);
            2: return -32'(($urandom % 100) + 1);
            3: return 32'sh7fff_ffff;
            default: return 32'sh8000_0000;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; in_valid = 1'b0; elem_result = '0; elem_idx = '0; vec_len = 7'd1;
        is_fp = 1'b0; dst_scalar = 1'b0; ovf_sticky = 1'b0; rd_sel = '0;
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R9 done in reset", {31'd0, done}, 32'd0);
        check("R9 ready in reset", {31'd0, in_ready}, 32'd0);
        rst = 1'b0;
        check_file("R9 reset clears");

        // R1 directed classes and R2 integer vector
        send(32'sd0,  0, 4, 1'b0, 1'b0, 1'b0, "R2");
        send(32'sd5,  1, 4, 1'b0, 1'b0, 1'b1, "R1");
        send(-32'sd7, 2, 4, 1'b0, 1'b0, 1'b0, "R1");
        send(32'sh8000_0000, 3, 4, 1'b0, 1'b0, 1'b1, "R2 last");
        check_file("R1 R2");
        // R3 floating-point vector
        send(32'sd9, 0, 2, 1'b1, 1'b0, 1'b0, "R3");
        send(-32'sd1, 1, 2, 1'b1, 1'b0, 1'b1, "R3 last");
        check_file("R3");
        // R4 wrap
        send(32'sd3, 40, 64, 1'b1, 1'b0, 1'b0, "R4");
        send(-32'sd3, 63, 64, 1'b0, 1'b0, 1'b1, "R4 last");
        check_file("R4 wrap");
        // R5 scalar
        send(-32'sd4, 17, 20, 1'b0, 1'b1, 1'b0, "R5");
        send(32'sd4, 19, 20, 1'b1, 1'b1, 1'b1, "R5 last");
        check_file("R5 scalar");
        // R7 ignored inputs with valid low
        @(negedge clk);
        elem_result = -32'sd99; elem_idx = 6'd5; is_fp = 1'b0; dst_scalar = 1'b1;
        ovf_sticky = 1'b1; vec_len = 7'd6;
        repeat (4) @(negedge clk);
        check("R8 no done while idle", {31'd0, done}, 32'd0);
        check_file("R7 idle");

        // random vectors R1..R8
        for (int v = 0; v < 40; v++) begin
            int vl = int'($urandom % 64) + 1;
            logic fp = 1'($urandom);
            logic sc = (($urandom % 6) == 0);
            for (int i = 0; i < vl; i++)
                send(rand_result(), i, vl, fp, sc, 1'($urandom), "random");
            check_file("R6 random batch");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule